// File: doc/BRIEF.md
# Noise Source Health Test Monitor

This block watches a digitized one-bit noise stream and decides whether the stream is still fit to be used as a seed for random output. It receives one sample per cycle in which `smp_valid` is high. It runs three statistical checks on the stream at the same time. The repetition check catches a bit value that is stuck. The adaptive proportion check catches a stream that is biased towards one value. The pair-alternation check catches a stream that toggles in a regular pattern.

A start request captures the threshold word and then waits for the source to settle. Next comes a fixed start-up phase, and after that the block checks without end. If any check trips, the block sets a fault state that it holds until the next start request. The surrounding logic reads `startup_done` as permission to produce random output. It sets its own sticky error flag from `seed_err_set`. Recovery always means a new start request, and that repeats the whole settle and start-up sequence.

Top module: `nsm_health_monitor`

## Requirements
- R1: After reset, `startup_done`, `seed_err_now` and `seed_err_set` are 0, and samples presented before any start request are ignored.
- R2: A start request in cycle 0 makes the block ignore samples in cycles 1 to 16. The first sample counted by the checks is the one presented in cycle 17.
- R3: Repetition check: a sample that extends a run of equal values beyond the limit in `cfg_word[7:0]` (default 40) is a failure. With the default limit, the 41st equal sample in a row fails.
- R4: Proportion check: windows of 1024 accepted samples do not overlap, and the sample after a window's last sample opens the next window. A failure occurs when the value of a window's first sample appears more often than the limit in `cfg_word[31:16]` (default 628) within that window.
- R5: Pair-alternation check: accepted samples are grouped into non-overlapping pairs, starting with the first sample after the start request. A pair is alternating if its two bits differ. A failure occurs when the number of alternating pairs in a row exceeds `cfg_word[15:8]` (default 42).
- R6: `startup_done` rises in the cycle after the 384th accepted sample, provided none of those samples failed. It then stays high while the checks keep running on every later sample.
- R7: On a failure, `seed_err_now` goes high in the next cycle and `seed_err_set` pulses for exactly that one cycle. `startup_done` goes low, and later samples are ignored until a start request.
- R8: A start request clears `seed_err_now` and `startup_done` in the next cycle, clears all check state, and runs the settle and start-up phases again.
- R9: The thresholds are captured from `cfg_word` in the cycle of the start request. Later changes to `cfg_word` have no effect until the next start request.
- R10: If the 384th start-up sample also fails a check, the failure wins: `startup_done` stays low and the fault of R7 is entered.
- R11: After start-up, a failure of any check on a later sample enters the fault state of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Soft restart: capture the thresholds and begin settle and start-up |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_bit | input | 1 | Digitized noise sample |
| cfg_word | input | 32 | Thresholds: [7:0] repetition, [15:8] pair alternation, [31:16] proportion |
| startup_done | output | 1 | Start-up passed and no fault since |
| seed_err_now | output | 1 | Fault state held until the next start request |
| seed_err_set | output | 1 | One-cycle pulse on entry to the fault state |

## Verification
The end of the start-up phase and a check failure can fall on the same sample, because the 384th accepted sample is the one that both completes start-up and gets tested. The bench provokes this by lowering the repetition limit to 5 through the start-time capture. It then shapes the stream so that the sixth equal bit in a row lands exactly on sample 384, while the port `cfg_word` is changed back to the default straight after the start request. On that sample the scoreboard expects `seed_err_set` high and `startup_done` low, and it expects `startup_done` to stay low on every later sample.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

    localparam int REP_LIM_W   = 8;
    localparam int TRN_LIM_W   = 8;
    localparam int PROP_LIM_W  = 16;
    localparam int WIN_SAMPLES = 1024;
    localparam int SU_SAMPLES  = 384;
    localparam int SETTLE_LEN  = 16;

    typedef struct packed {
        logic [PROP_LIM_W-1:0] prop_lim;
        logic [TRN_LIM_W-1:0]  trn_lim;
        logic [REP_LIM_W-1:0]  rep_lim;
    } hlth_cfg_t;

    localparam logic [31:0] CFG_DEFAULT = 32'h0274_2A28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_STARTUP,
        ST_RUN,
        ST_FAULT
    } mon_state_t;

    function automatic hlth_cfg_t unpack_cfg(input logic [31:0] w);
        hlth_cfg_t c;
        c.prop_lim = w[31:16];
        c.trn_lim  = w[15:8];
        c.rep_lim  = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/nsm_rep_test.sv
module nsm_rep_test
    import nsm_pkg::*;
#(
    parameter int CNT_W = REP_LIM_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 bit_i,
    input  logic [REP_LIM_W-1:0] limit,
    output logic                 fail
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] run_q, run_d;
    logic             last_q;
    logic             have_q;

    always_comb begin
        if (have_q && (bit_i == last_q)) begin
            run_d = (run_q == '1) ? run_q : run_q + ONE;
        end else begin
            run_d = ONE;
        end
    end

    assign fail = en && (run_d > CNT_W'(limit));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run_q  <= '0;
            last_q <= 1'b0;
            have_q <= 1'b0;
        end else if (en) begin
            run_q  <= run_d;
            last_q <= bit_i;
            have_q <= 1'b1;
        end
    end

    AST_REP_NEW_RUN: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && have_q && (bit_i != last_q)) |=> (run_q == ONE)) else $error("rep run restart"); // R3

    AST_REP_SEEN: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (have_q && run_q != '0)) else $error("rep run empty"); // R3

endmodule

// File: rtl/nsm_prop_test.sv
module nsm_prop_test
    import nsm_pkg::*;
#(
    parameter int WIN_LEN = WIN_SAMPLES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  en,
    input  logic                  bit_i,
    input  logic [PROP_LIM_W-1:0] limit,
    output logic                  fail
);

    localparam int IDX_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ref_q;
    logic             first;

    assign first = (idx_q == '0);

    always_comb begin
        if (first) begin
            cnt_d = ONE;
        end else if (bit_i == ref_q) begin
            cnt_d = cnt_q + ONE;
        end else begin
            cnt_d = cnt_q;
        end
    end

    assign fail = en && ({{(PROP_LIM_W){1'b0}}, cnt_d} > {{(CNT_W){1'b0}}, limit});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx_q <= '0;
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else if (en) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            cnt_q <= cnt_d;
            if (first) begin
                ref_q <= bit_i;
            end
        end
    end

    AST_PROP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && idx_q == IDX_LAST) |=> (idx_q == '0)) else $error("window wrap"); // R4

    AST_PROP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0) |-> (cnt_q <= CNT_W'(idx_q))) else $error("window count bound"); // R4

endmodule

// File: rtl/nsm_trans_test.sv
module nsm_trans_test
    import nsm_pkg::*;
#(
    parameter int CNT_W = TRN_LIM_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 en,
    input  logic                 bit_i,
    input  logic [TRN_LIM_W-1:0] limit,
    output logic                 fail
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             phase_q;
    logic             head_q;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    logic             alt;

    assign alt     = head_q ^ bit_i;
    assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + ONE;
    assign fail    = en && phase_q && alt && (cnt_inc > CNT_W'(limit));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= 1'b0;
            head_q  <= 1'b0;
            cnt_q   <= '0;
        end else if (en) begin
            phase_q <= ~phase_q;
            if (!phase_q) begin
                head_q <= bit_i;
            end else begin
                cnt_q <= alt ? cnt_inc : '0;
            end
        end
    end

    AST_TRN_PHASE: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> (phase_q != $past(phase_q))) else $error("pair phase"); // R5

    AST_TRN_BREAK: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && phase_q && !alt) |=> (cnt_q == '0)) else $error("pair break"); // R5

endmodule

// File: rtl/nsm_seq_ctrl.sv
module nsm_seq_ctrl
    import nsm_pkg::*;
#(
    parameter int STARTUP_SAMPLES = SU_SAMPLES,
    parameter int SETTLE_CYC      = SETTLE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic smp_valid,
    input  logic any_fail,
    output logic smp_en,
    output logic startup_done,
    output logic seed_err_now,
    output logic seed_err_set
);

    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam int SU_W  = (STARTUP_SAMPLES > 1) ? $clog2(STARTUP_SAMPLES) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);
    localparam logic [SU_W-1:0]  SU_LAST  = SU_W'(STARTUP_SAMPLES - 1);

    mon_state_t       st_q, st_d;
    logic [SET_W-1:0] set_cnt_q, set_cnt_d;
    logic [SU_W-1:0]  su_cnt_q, su_cnt_d;
    logic             pulse_q, pulse_d;

    assign smp_en = smp_valid && !start_req &&
                    ((st_q == ST_STARTUP) || (st_q == ST_RUN));

    always_comb begin
        st_d      = st_q;
        set_cnt_d = set_cnt_q;
        su_cnt_d  = su_cnt_q;
        pulse_d   = 1'b0;
        if (start_req) begin
            st_d      = ST_SETTLE;
            set_cnt_d = '0;
            su_cnt_d  = '0;
        end else begin
            case (st_q)
                ST_SETTLE: begin
                    if (set_cnt_q == SET_LAST) begin
                        st_d = ST_STARTUP;
                    end else begin
                        set_cnt_d = set_cnt_q + 1'b1;
                    end
                end
                ST_STARTUP: begin
                    if (smp_en) begin
                        if (any_fail) begin
                            st_d    = ST_FAULT;
                            pulse_d = 1'b1;
                        end else if (su_cnt_q == SU_LAST) begin
                            st_d = ST_RUN;
                        end else begin
                            su_cnt_d = su_cnt_q + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (smp_en && any_fail) begin
                        st_d    = ST_FAULT;
                        pulse_d = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            set_cnt_q <= '0;
            su_cnt_q  <= '0;
            pulse_q   <= 1'b0;
        end else begin
            st_q      <= st_d;
            set_cnt_q <= set_cnt_d;
            su_cnt_q  <= su_cnt_d;
            pulse_q   <= pulse_d;
        end
    end

    assign startup_done = (st_q == ST_RUN);
    assign seed_err_now = (st_q == ST_FAULT);
    assign seed_err_set = pulse_q;

    AST_SET_PULSE: assert property (@(posedge clk) disable iff (rst)
        seed_err_set |=> !seed_err_set) else $error("set pulse too long"); // R7

    AST_SET_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        seed_err_set |-> seed_err_now) else $error("set without flag"); // R7

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seed_err_now && !start_req) |=> seed_err_now) else $error("fault released"); // R7

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(startup_done && seed_err_now)) else $error("done during fault"); // R7

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start_req |=> (!seed_err_now && !startup_done)) else $error("start not clearing"); // R8

    AST_FAIL_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (smp_en && any_fail) |=> seed_err_set) else $error("fail not latched"); // R11

endmodule

// File: rtl/nsm_health_monitor.sv
module nsm_health_monitor
    import nsm_pkg::*;
#(
    parameter int WIN_LEN         = WIN_SAMPLES,
    parameter int STARTUP_SAMPLES = SU_SAMPLES,
    parameter int SETTLE_CYC      = SETTLE_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic        smp_valid,
    input  logic        smp_bit,
    input  logic [31:0] cfg_word,
    output logic        startup_done,
    output logic        seed_err_now,
    output logic        seed_err_set
);

    hlth_cfg_t cfg_q;
    logic      smp_en;
    logic      rep_fail, prop_fail, trn_fail, any_fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= unpack_cfg(CFG_DEFAULT);
        end else if (start_req) begin
            cfg_q <= unpack_cfg(cfg_word);
        end
    end

    nsm_rep_test u_rep (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_req),
        .en    (smp_en),
        .bit_i (smp_bit),
        .limit (cfg_q.rep_lim),
        .fail  (rep_fail)
    );

    nsm_prop_test #(
        .WIN_LEN (WIN_LEN)
    ) u_prop (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_req),
        .en    (smp_en),
        .bit_i (smp_bit),
        .limit (cfg_q.prop_lim),
        .fail  (prop_fail)
    );

    nsm_trans_test u_trn (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_req),
        .en    (smp_en),
        .bit_i (smp_bit),
        .limit (cfg_q.trn_lim),
        .fail  (trn_fail)
    );

    assign any_fail = rep_fail | prop_fail | trn_fail;

    nsm_seq_ctrl #(
        .STARTUP_SAMPLES (STARTUP_SAMPLES),
        .SETTLE_CYC      (SETTLE_CYC)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .smp_valid    (smp_valid),
        .any_fail     (any_fail),
        .smp_en       (smp_en),
        .startup_done (startup_done),
        .seed_err_now (seed_err_now),
        .seed_err_set (seed_err_set)
    );

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        !start_req |=> $stable(cfg_q)) else $error("thresholds moved"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!startup_done && !seed_err_now && !start_req && !smp_en) |=> !seed_err_set) else $error("spurious set"); // R1

endmodule

// File: tb/nsm_health_monitor_test.sv
`timescale 1ns/100ps
module nsm_health_monitor_test;

    localparam int NONE = 1000000;
    localparam logic [31:0] CFG_DEF  = 32'h0274_2A28;
    localparam logic [31:0] CFG_REP5 = 32'h0274_2A05;

    localparam int M_ONES = 0;
    localparam int M_ALT  = 1;
    localparam int M_PAIR = 2;
    localparam int M_APT  = 3;
    localparam int M_APT2 = 4;
    localparam int M_EDGE = 5;

    typedef struct {
        logic  done;
        logic  err;
        logic  set;
        int    idx;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_bit = 1'b0;
    logic [31:0] cfg_word = CFG_DEF;
    logic        startup_done, seed_err_now, seed_err_set;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    nsm_health_monitor uut (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .smp_valid    (smp_valid),
        .smp_bit      (smp_bit),
        .cfg_word     (cfg_word),
        .startup_done (startup_done),
        .seed_err_now (seed_err_now),
        .seed_err_set (seed_err_set)
    );

    function automatic logic bit_of(input int mode, input int i);
        case (mode)
            M_ONES: return 1'b1;
            M_ALT:  return i[0];
            M_PAIR: return i[1];
            M_APT:  return (i % 4) != 2;
            M_APT2: return (i == 0) ? 1'b0 : ((i - 1) % 4) != 2;
            M_EDGE: return (i >= 380) ? 1'b1 : i[1];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // monitor: pops expected items after each accepted-sample edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, startup_done, e.done, $sformatf("startup_done@%0d", e.idx));
                check(e.tag, seed_err_now, e.err,  $sformatf("seed_err_now@%0d", e.idx));
                check(e.tag, seed_err_set, e.set,  $sformatf("seed_err_set@%0d", e.idx));
            end
        end
    end

    // driver: presents samples and pushes the outcome the requirements predict
    task automatic run_stream(input int mode, input int n, input int fail_at,
                              input int done_at, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            smp_valid = 1'b1;
            smp_bit   = bit_of(mode, i);
            @(posedge clk);
            #0.5;
            e.done = (i >= done_at) && (i < fail_at);
            e.err  = (i >= fail_at);
            e.set  = (i == fail_at);
            e.idx  = i;
            e.tag  = tag;
            sb_q.push_back(e);
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    // start request, then 16 settle cycles fed with ones that must be ignored (R2)
    task automatic do_start(input logic [31:0] cfg_at, input logic [31:0] cfg_later);
        @(negedge clk);
        cfg_word  = cfg_at;
        start_req = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        start_req = 1'b0;
        cfg_word  = cfg_later;
        check("R8", seed_err_now, 1'b0, "err after start");
        check("R8", startup_done, 1'b0, "done after start");
        for (int k = 0; k < 16; k++) begin
            smp_valid = 1'b1;
            smp_bit   = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", startup_done, 1'b0, "reset done");
        check("R1", seed_err_now, 1'b0, "reset err");
        check("R1", seed_err_set, 1'b0, "reset set");

        // R1: samples before any start are ignored
        run_stream(M_ONES, 60, NONE, NONE, "R1");

        // R2 R3 R7: 41st equal sample after settle fails; settle leak would fail earlier
        do_start(CFG_DEF, CFG_DEF);
        run_stream(M_ONES, 50, 40, NONE, "R3");

        // R5 R8: restart clears the fault, alternating pairs fail on the 43rd pair
        do_start(CFG_DEF, CFG_DEF);
        run_stream(M_ALT, 100, 85, NONE, "R5");

        // R4 R6 R11: biased stream passes start-up, trips proportion at sample 837
        do_start(CFG_DEF, CFG_DEF);
        run_stream(M_APT, 900, 837, 383, "R4");

        // R4: second window opens at sample 1024 with a new reference value
        do_start(CFG_DEF, CFG_DEF);
        run_stream(M_APT2, 1870, 1861, 383, "R4");

        // R9 R10: limit 5 captured at start, failure on the last start-up sample
        do_start(CFG_REP5, CFG_DEF);
        run_stream(M_EDGE, 390, 383, NONE, "R10");

        // R6: clean stream keeps startup_done high
        do_start(CFG_DEF, CFG_REP5);
        run_stream(M_PAIR, 1500, NONE, 383, "R6");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule